// File: doc/BRIEF.md
# Dual LFSR Random Bit Test Source

This block is the test-mode datapath of a random number generator. Two 32-bit Galois shift registers each have their own feedback polynomial and start value. Two samplers each pick one bit from one of several sources. The sources are an external oscillator bit, a constant zero, or a selectable low bit of the sampler's own shift register. The two sampled bits are combined by XOR and shifted into a 32-bit output word.

Sampling is paced by a clock-trigger event. The event is held back until a cycle counter reaches a lower bound and the counter's low bits, selected by a mask, are zero. Once the counter reaches an upper bound, the event fires regardless. Every event is also reported as a one-cycle interrupt pulse.

A consumer waits for the ready flag, takes the word, and acknowledges it. The acknowledge starts a new collection. When test mode is off, each shift register simply follows its start value. This lets software set a known state before it enables stepping.

Top module: `rng_test_source`

## Requirements
- R1: `en_o` and `test_o` show `ctrl_i[12]` (enable) and `ctrl_i[11]` (test mode) one clock after they are sampled. All outputs are zero after reset.
- R2: While test mode is off, shift register A loads `seed_a_i` on every clock and register B loads `seed_b_i`. Step requests have no effect in this state.
- R3: In test mode, a clock with `step_wr_i` high advances register A if `step_word_i[12]` is set, and advances register B if `step_word_i[16]` is set. One advance is `next = (s >> 1) ^ (s[0] ? poly : 0)`. Otherwise the register holds its value.
- R4: `smp_cfg_i` carries the source fields and tap fields, decoded as follows:
  - Sampler A's source is in bits 5:4 and its tap in bits 11:8. Sampler B's source is in bits 7:6 and its tap in bits 15:12.
  - Source code 0 selects `osc_i`.
  - Source code 2 selects bit `tap` of the sampler's own shift register.
  - Source codes 1 and 3 give a constant 0.
- R5: On each clock-trigger event, while the block is enabled and not ready, the XOR of the two sampler bits is shifted into bit 0 of the word. Older bits move toward bit 31.
- R6: `rnd_ready_o` rises on the clock that stores the 32nd bit. While it is high, the word stays unchanged.
- R7: `rd_ack_i` high while ready clears `rnd_ready_o` on the next clock and restarts the 32-bit collection. The acknowledge takes precedence over a trigger event on the same clock.
- R8: A cycle counter restarts at 0 on each event and otherwise counts up while the block is enabled. The event fires in either of two cases:
  - the count is at least `trig_lo_i` and (count[15:0] & `trig_bound_i[31:16]`) is zero;
  - the count is at least `trig_bound_i[15:0]`.

  `trig_irq_o` pulses one clock after each event.
- R9: While enable is off, the counter, the collected bit count and the ready flag are cleared, and no event or interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 32 | Control word: bit 11 test mode, bit 12 enable |
| step_wr_i | input | 1 | Strobe that qualifies `step_word_i` |
| step_word_i | input | 32 | Step request: bit 12 register A, bit 16 register B |
| poly_a_i | input | 32 | Feedback polynomial of register A |
| seed_a_i | input | 32 | Start value of register A |
| poly_b_i | input | 32 | Feedback polynomial of register B |
| seed_b_i | input | 32 | Start value of register B |
| smp_cfg_i | input | 16 | Sampler source and tap fields |
| osc_i | input | 1 | Modelled oscillator bit |
| trig_lo_i | input | 32 | Event lower bound |
| trig_bound_i | input | 32 | Upper bound [15:0], mask [31:16] |
| rd_ack_i | input | 1 | Word taken acknowledge |
| rnd_word_o | output | 32 | Collected random word |
| rnd_ready_o | output | 1 | Word complete |
| trig_irq_o | output | 1 | Clock-trigger interrupt pulse |
| en_o | output | 1 | Registered enable |
| test_o | output | 1 | Registered test mode |

## Verification
The assertions check the following on every cycle:
- a shift register tracks its start value outside test mode, and holds when no step is requested;
- the counter restarts after its upper bound is reached;
- the word is frozen while ready;
- an acknowledge drops ready;
- no interrupt occurs while disabled.

Other behaviours show only in the bench's scenarios. These are the exact bit streams produced by polynomial stepping, the XOR of two sources, the decoding of every source code, and the spacing of events under the lower-bound, mask and upper-bound conditions. A behavioural model compares every output on every clock against these scenarios.

// File: rtl/rngt_pkg.sv
package rngt_pkg;

    typedef enum logic [1:0] {
        SRC_OSC  = 2'd0,
        SRC_RSVD = 2'd1,
        SRC_LFSR = 2'd2,
        SRC_NONE = 2'd3
    } src_e;

    localparam int LFSR_W   = 32;
    localparam int TAP_W    = 4;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 32;
    localparam int BOUND_W  = 16;

    function automatic logic [LFSR_W-1:0] galois_next(
        input logic [LFSR_W-1:0] s,
        input logic [LFSR_W-1:0] poly
    );
        return (s >> 1) ^ (s[0] ? poly : '0);
    endfunction

endpackage

// File: rtl/rngt_lfsr.sv
module rngt_lfsr
    import rngt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_i,
    input  logic              step_i,
    input  logic [LFSR_W-1:0] poly_i,
    input  logic [LFSR_W-1:0] seed_i,
    output logic [LFSR_W-1:0] state_o
);

    typedef struct packed {
        logic [LFSR_W-1:0] st;
    } lfsr_t;

    lfsr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!test_i) begin
            r_d.st = seed_i;
        end else if (step_i) begin
            r_d.st = galois_next(r_q.st, poly_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign state_o = r_q.st;

    AST_SEED_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !test_i |=> (state_o == $past(seed_i)));  // R2

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (test_i && !step_i) |=> $stable(state_o));  // R3

endmodule

// File: rtl/rngt_sampler.sv
module rngt_sampler
    import rngt_pkg::*;
(
    input  logic [1:0]        src_i,
    input  logic [TAP_W-1:0]  tap_i,
    input  logic [LFSR_W-1:0] state_i,
    input  logic              osc_i,
    output logic              bit_o
);

    src_e src;

    always_comb begin
        src = src_e'(src_i);
        unique case (src)
            SRC_OSC:  bit_o = osc_i;
            SRC_LFSR: bit_o = state_i[tap_i];
            default:  bit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/rngt_trigger.sv
module rngt_trigger
    import rngt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic [CNT_W-1:0]   lo_i,
    input  logic [BOUND_W-1:0] hi_i,
    input  logic [BOUND_W-1:0] mask_i,
    output logic               fire_o,
    output logic               irq_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } trig_t;

    trig_t r_d, r_q;
    logic  lo_ok, hi_hit;

    always_comb begin
        lo_ok  = (r_q.cnt >= lo_i) && ((r_q.cnt[BOUND_W-1:0] & mask_i) == '0);
        hi_hit = (r_q.cnt >= CNT_W'(hi_i));
        fire_o = en_i && (lo_ok || hi_hit);

        r_d     = r_q;
        r_d.irq = fire_o;
        if (!en_i || fire_o)        r_d.cnt = '0;
        else if (r_q.cnt != CNT_MAX) r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign irq_o = r_q.irq;

    AST_HI_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (r_q.cnt >= CNT_W'(hi_i))) |=> (r_q.cnt == '0));  // R8

    AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !irq_o);  // R9

endmodule

// File: rtl/rngt_collect.sv
module rngt_collect
    import rngt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              fire_i,
    input  logic              bit_i,
    input  logic              ack_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ready_o
);

    localparam int NB_W = $clog2(WORD_W + 1);
    localparam logic [NB_W-1:0] LAST = NB_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [NB_W-1:0]   nbits;
        logic              ready;
    } col_t;

    col_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!en_i) begin
            r_d = '0;
        end else if (r_q.ready) begin
            if (ack_i) begin
                r_d.ready = 1'b0;
                r_d.nbits = '0;
            end
        end else if (fire_i) begin
            r_d.word  = {r_q.word[WORD_W-2:0], bit_i};
            r_d.nbits = r_q.nbits + 1'b1;
            r_d.ready = (r_q.nbits == LAST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign word_o  = r_q.word;
    assign ready_o = r_q.ready;

    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && en_i) |=> $stable(word_o));  // R6

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && ack_i) |=> !ready_o);  // R7

endmodule

// File: rtl/rng_test_source.sv
module rng_test_source
    import rngt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ctrl_i,
    input  logic        step_wr_i,
    input  logic [31:0] step_word_i,
    input  logic [31:0] poly_a_i,
    input  logic [31:0] seed_a_i,
    input  logic [31:0] poly_b_i,
    input  logic [31:0] seed_b_i,
    input  logic [15:0] smp_cfg_i,
    input  logic        osc_i,
    input  logic [31:0] trig_lo_i,
    input  logic [31:0] trig_bound_i,
    input  logic        rd_ack_i,
    output logic [31:0] rnd_word_o,
    output logic        rnd_ready_o,
    output logic        trig_irq_o,
    output logic        en_o,
    output logic        test_o
);

    localparam int NUM_SRC    = 2;
    localparam int CTL_TEST   = 11;
    localparam int CTL_EN     = 12;
    localparam int STEP_BASE  = 12;
    localparam int STEP_PITCH = 4;
    localparam int SRC_BASE   = 4;
    localparam int TAP_BASE   = 8;

    typedef struct packed {
        logic en;
        logic test;
    } mode_t;

    mode_t m_d, m_q;

    logic test_mode, enable;
    logic [LFSR_W-1:0] poly  [NUM_SRC];
    logic [LFSR_W-1:0] seed  [NUM_SRC];
    logic [LFSR_W-1:0] state [NUM_SRC];
    logic [NUM_SRC-1:0] smp_bit;
    logic fire;

    assign test_mode = ctrl_i[CTL_TEST];
    assign enable    = ctrl_i[CTL_EN];
    assign poly[0] = poly_a_i;
    assign poly[1] = poly_b_i;
    assign seed[0] = seed_a_i;
    assign seed[1] = seed_b_i;

    logic unused_bits;
    assign unused_bits = ^{ctrl_i[31:13], ctrl_i[10:0], step_word_i[31:17],
                           step_word_i[15:13], step_word_i[11:0], smp_cfg_i[3:0]};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        rngt_lfsr u_lfsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .test_i  (test_mode),
            .step_i  (step_wr_i && step_word_i[STEP_BASE + STEP_PITCH*i]),
            .poly_i  (poly[i]),
            .seed_i  (seed[i]),
            .state_o (state[i])
        );
        rngt_sampler u_smp (
            .src_i   (smp_cfg_i[SRC_BASE + 2*i +: 2]),
            .tap_i   (smp_cfg_i[TAP_BASE + TAP_W*i +: TAP_W]),
            .state_i (state[i]),
            .osc_i   (osc_i),
            .bit_o   (smp_bit[i])
        );
    end

    rngt_trigger u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (enable),
        .lo_i   (trig_lo_i),
        .hi_i   (trig_bound_i[BOUND_W-1:0]),
        .mask_i (trig_bound_i[2*BOUND_W-1:BOUND_W]),
        .fire_o (fire),
        .irq_o  (trig_irq_o)
    );

    rngt_collect u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (enable),
        .fire_i  (fire),
        .bit_i   (^smp_bit),
        .ack_i   (rd_ack_i),
        .word_o  (rnd_word_o),
        .ready_o (rnd_ready_o)
    );

    always_comb begin
        m_d.en   = enable;
        m_d.test = test_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign en_o   = m_q.en;
    assign test_o = m_q.test;

    AST_MODE_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (en_o == $past(ctrl_i[CTL_EN]) && test_o == $past(ctrl_i[CTL_TEST])));  // R1

endmodule

// File: tb/rng_test_source_test.sv
module rng_test_source_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl_i = '0, step_word_i = '0;
    logic        step_wr_i = 1'b0, osc_i = 1'b0, rd_ack_i = 1'b0;
    logic [31:0] poly_a_i = '0, seed_a_i = '0, poly_b_i = '0, seed_b_i = '0;
    logic [15:0] smp_cfg_i = '0;
    logic [31:0] trig_lo_i = '0, trig_bound_i = '0;
    logic [31:0] rnd_word_o;
    logic        rnd_ready_o, trig_irq_o, en_o, test_o;

    int errors = 0, checks = 0, cyc = 0;
    bit done = 0;

    always #10 clk = ~clk;  // 50 MHz

    rng_test_source uut (.*);

    // behavioural reference model
    bit [31:0] m_a, m_b, m_word, m_cnt;
    int  m_bits;
    bit  m_ready, m_irq, m_en, m_test;

    function automatic bit pick(bit [1:0] src, bit [3:0] tap, bit [31:0] s, bit osc);
        if (src == 0) return osc;
        if (src == 2) return s[tap];
        return 1'b0;
    endfunction

    function automatic bit [31:0] adv(bit [31:0] s, bit [31:0] p);
        bit [31:0] n = s >> 1;
        if (s[0]) n = n ^ p;
        return n;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_word = 0; m_cnt = 0; m_bits = 0;
            m_ready = 0; m_irq = 0; m_en = 0; m_test = 0;
        end else begin
            bit en, tst, trig, sbit;
            bit [31:0] na, nb;
            en  = ctrl_i[12];
            tst = ctrl_i[11];
            trig = en && (((m_cnt >= trig_lo_i) && ((m_cnt[15:0] & trig_bound_i[31:16]) == 0))
                          || (m_cnt >= {16'h0, trig_bound_i[15:0]}));
            sbit = pick(smp_cfg_i[5:4], smp_cfg_i[11:8], m_a, osc_i)
                 ^ pick(smp_cfg_i[7:6], smp_cfg_i[15:12], m_b, osc_i);
            na = !tst ? seed_a_i : (step_wr_i && step_word_i[12]) ? adv(m_a, poly_a_i) : m_a;
            nb = !tst ? seed_b_i : (step_wr_i && step_word_i[16]) ? adv(m_b, poly_b_i) : m_b;
            if (!en) begin
                m_cnt = 0; m_bits = 0; m_ready = 0; m_word = 0;
            end else begin
                if (m_ready) begin
                    if (rd_ack_i) begin m_ready = 0; m_bits = 0; end
                end else if (trig) begin
                    m_word = {m_word[30:0], sbit};
                    m_bits++;
                    if (m_bits == 32) m_ready = 1;
                end
                if (trig) m_cnt = 0;
                else if (m_cnt != 32'hFFFF_FFFF) m_cnt = m_cnt + 1;
            end
            m_a = na; m_b = nb;
            m_irq = trig; m_en = en; m_test = tst;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 en", {31'h0, en_o}, {31'h0, m_en});
            check("R1 test", {31'h0, test_o}, {31'h0, m_test});
            check("R6 ready", {31'h0, rnd_ready_o}, {31'h0, m_ready});
            check("R5 word", rnd_word_o, m_word);
            check("R8 irq", {31'h0, trig_irq_o}, {31'h0, m_irq});
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
            finish_run();
        end
    end

    task automatic restart(logic [31:0] c);
        ctrl_i = '0;
        @(negedge clk);
        ctrl_i = c;
    endtask

    task automatic count_irq(int n, output int k);
        k = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (trig_irq_o) k++;
        end
    endtask

    localparam logic [31:0] EN = 32'h1000, TST = 32'h0800;

    initial begin
        int k;
        repeat (3) @(negedge clk);
        check("R1 reset word", rnd_word_o, 0);
        check("R1 reset flags", {27'h0, rnd_ready_o, trig_irq_o, en_o, test_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: test off, register A follows an odd seed, tap 0 via source 2
        seed_a_i = 32'h1234_5679; poly_a_i = 32'h8000_0057;
        seed_b_i = 32'hCAFE_F00D; poly_b_i = 32'hA300_0001;
        smp_cfg_i = 16'h00E0 | 16'h0020;  // A src 2 tap 0, B src 3
        step_wr_i = 1'b1; step_word_i = 32'h0001_1000;
        restart(EN);
        repeat (40) @(negedge clk);
        check("R2 seed held, steps ignored", rnd_word_o, 32'hFFFF_FFFF);
        check("R6 ready after 32", {31'h0, rnd_ready_o}, 1);

        // R3: test on, step A only, tap 3
        smp_cfg_i = 16'h03E0;
        step_word_i = 32'h0000_1000;
        restart(EN | TST);
        repeat (40) @(negedge clk);
        check("R3 stepped stream A", rnd_word_o, m_word);

        // R7: acknowledge clears ready and restarts
        rd_ack_i = 1'b1; @(negedge clk); rd_ack_i = 1'b0;
        check("R7 ack clears ready", {31'h0, rnd_ready_o}, 0);
        repeat (40) @(negedge clk);
        check("R7 new word ready", {31'h0, rnd_ready_o}, 1);

        // R3: step B only via bit 16, B src 2 tap 5, A dummy
        smp_cfg_i = 16'h50B0;
        step_word_i = 32'h0001_0000;
        restart(EN | TST);
        repeat (40) @(negedge clk);
        check("R3 stepped stream B", rnd_word_o, m_word);

        // R4: reserved source gives zero with oscillator high
        osc_i = 1'b1; smp_cfg_i = 16'h00D0;  // A src 1, B src 3
        restart(EN);
        repeat (40) @(negedge clk);
        check("R4 reserved is zero", rnd_word_o, 0);
        smp_cfg_i = 16'h00C0;  // A src 0 oscillator
        restart(EN);
        repeat (40) @(negedge clk);
        check("R4 oscillator source", rnd_word_o, 32'hFFFF_FFFF);
        // R5: oscillator XOR register B bit (seed odd, tap 0) cancels
        seed_b_i = 32'h0000_0001; smp_cfg_i = 16'h0080;
        restart(EN);
        repeat (40) @(negedge clk);
        check("R5 xor of samplers", rnd_word_o, 0);
        // R5: oscillator pattern alternation
        smp_cfg_i = 16'h00C0;
        restart(EN);
        for (int i = 0; i < 36; i++) begin osc_i = i[0]; @(negedge clk); end
        check("R5 alternating shift", rnd_word_o, m_word);
        osc_i = 1'b0;

        // R8: lower bound only, period 6
        trig_lo_i = 5; trig_bound_i = 32'h0000_0064;
        restart(EN); count_irq(60, k);
        check("R8 lower bound spacing", k, 10);
        // R8: mask 3 with lower bound 2, period 5
        trig_lo_i = 2; trig_bound_i = 32'h0003_03E8;
        restart(EN); count_irq(60, k);
        check("R8 mask spacing", k, 12);
        // R8: upper bound forces, period 4
        trig_lo_i = 50; trig_bound_i = 32'h0000_0003;
        restart(EN); count_irq(60, k);
        check("R8 upper bound forces", k, 15);

        // R9: disable clears ready and silences events
        trig_lo_i = 0; trig_bound_i = 0;
        restart(EN); repeat (40) @(negedge clk);
        ctrl_i = '0;
        @(negedge clk);
        check("R9 ready cleared", {31'h0, rnd_ready_o}, 0);
        count_irq(20, k);
        check("R9 no events when off", k, 0);

        finish_run();
    end

endmodule